// File: doc/BRIEF.md
# Center-Aligned Three-Phase PWM Generator

This block drives a three-phase voltage-source inverter. For each of phases A, B and C it produces a high-side and a low-side gate signal from a triangular timebase. The two signals of one phase are complementary, with a programmable dead gap between them. The switching period, the three duty values and the dead time are taken from plain configuration inputs. They are copied into working registers only at fixed points of the period: always at the start, and also at the midpoint when double update is selected. Single update therefore gives pulses that are symmetric about the midpoint, and double update allows asymmetric pulses.

The block emits a one-cycle sync pulse at the start of every switching period. It can also restart its period from an external sync pulse. An active-low trip input forces all six gates to their off level at once, without waiting for a clock edge. The trip is held by a sticky flag until software clears it.

All pins are plain control and status signals. No data stream passes through the block, so it has no valid/ready handshake and applies no back-pressure.

Top module: `pwm3_center_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, all six gate outputs sit at the off level, `sync_out` is 0 and `tripped` is 0.
- R2: With H = max(floor(period/2), 1), the switching period is 2H clock cycles. `sync_out` is high for exactly one cycle at the start of each period.
- R3: A duty value is read as 16-bit two's complement and clamped to k in [0, H]: negative or zero gives k = 0, and a value above H gives k = H. The raw high-side request is on for 2k cycles per period, centred on the period midpoint. k = 0 keeps the high side off for the whole period, and k = H keeps it on for the whole period.
- R4: Every turn-on edge is delayed by `dead` cycles. For 0 < k < H, the high side is on for max(2k - dead, 0) cycles per period and the low side for max(2H - 2k - dead, 0) cycles. The high and low outputs of one phase are never both at the on level.
- R5: With `dbl_upd` = 0, changes to period, duty and dead time take effect only at the next period start.
- R6: With `dbl_upd` = 1, duty values are also loaded at the midpoint, between triangle counts H-1 and H. Period and dead time still load only at the period start.
- R7: With `act_high` = 1 the on level is 1 and the off level is 0. With `act_high` = 0 both levels are inverted.
- R8: When `sync_en` and `sync_in` are both high at a clock edge, the period restarts and its values reload, and `sync_out` is high in the next cycle. With `sync_en` = 0, `sync_in` has no effect.
- R9: When `trip_n` goes low, all six outputs go to the off level and `tripped` goes to 1, with no clock edge needed.
- R10: Once tripped, the outputs stay off until `trip_clr` is high at a clock edge while `trip_n` is high. A clear while `trip_n` is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period | input | 16 | Switching period in clock cycles |
| duty_a | input | 16 | Phase A duty, two's complement, in half-period counts |
| duty_b | input | 16 | Phase B duty |
| duty_c | input | 16 | Phase C duty |
| dead | input | 8 | Dead time in cycles |
| dbl_upd | input | 1 | 1 selects an extra duty load at the midpoint |
| act_high | input | 1 | Output polarity: 1 means active-high |
| sync_en | input | 1 | Enables period restart from `sync_in` |
| sync_in | input | 1 | External sync pulse |
| trip_n | input | 1 | Asynchronous active-low shutdown |
| trip_clr | input | 1 | Clears the sticky trip flag |
| hi_out | output | 3 | High-side gates, bit 0 = A, bit 1 = B, bit 2 = C |
| lo_out | output | 3 | Low-side gates, same bit order |
| sync_out | output | 1 | One-cycle pulse at each period start |
| tripped | output | 1 | Sticky trip flag |

## Verification
The bench builds the block with its default widths: a 16-bit timebase and an 8-bit dead-time counter. It programs short periods of 16 to 40 cycles, so every configuration settles within two periods and many configurations fit in one run. These periods still cover odd periods, negative duty values, and duty values at and beyond the half period. The dead times used range from zero up to values longer than a pulse, so both the complementary case and the case where a pulse is dropped entirely are reached.

// File: rtl/pwm3_pkg.sv
`timescale 1ns/1ps
package pwm3_pkg;
  localparam int PHASES = 3;
  typedef enum logic {UPD_SINGLE = 1'b0, UPD_DOUBLE = 1'b1} upd_mode_e;
endpackage

// File: rtl/pwm3_timebase.sv
`timescale 1ns/1ps
module pwm3_timebase
  import pwm3_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] half,
  input  logic             ext_restart,
  input  upd_mode_e        mode,
  output logic [CNT_W-1:0] tri_cnt,
  output logic             start_ld,
  output logic             mid_ld,
  output logic             sync_out,
  output logic             booting
);
  logic [CNT_W-1:0] pos;
  logic [CNT_W-1:0] last;
  logic             at_end;

  assign last     = (half << 1) - CNT_W'(1);
  assign at_end   = (pos >= last);
  assign start_ld = booting | at_end | ext_restart;
  assign mid_ld   = (mode == UPD_DOUBLE) && !start_ld && (pos == half - CNT_W'(1));
  assign tri_cnt  = (pos < half) ? pos : (last - pos);
  assign sync_out = (pos == '0) && !booting;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos     <= '0;
      booting <= 1'b1;
    end else begin
      booting <= 1'b0;
      if (start_ld) pos <= '0;
      else          pos <= pos + CNT_W'(1);
    end
  end

  // position never leaves the active period
  assert_pos_in_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pos <= last);

  // a sync pulse lasts one cycle unless an external restart follows it
  assert_sync_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_out && !ext_restart) |=> !sync_out);
endmodule

// File: rtl/pwm3_shadow.sv
`timescale 1ns/1ps
module pwm3_shadow
  import pwm3_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DT_W  = 8,
  parameter int NPH   = PHASES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_ld,
  input  logic                 mid_ld,
  input  upd_mode_e            mode,
  input  logic [CNT_W-1:0]     per_in,
  input  logic [NPH*CNT_W-1:0] duty_in,
  input  logic [DT_W-1:0]      dt_in,
  output logic [CNT_W-1:0]     half_act,
  output logic [NPH*CNT_W-1:0] duty_act,
  output logic [DT_W-1:0]      dt_act
);
  logic [CNT_W-1:0] half_raw;
  logic [CNT_W-1:0] half_nx;

  assign half_raw = per_in >> 1;
  assign half_nx  = (half_raw == '0) ? CNT_W'(1) : half_raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_act <= CNT_W'(1);
      dt_act   <= '0;
    end else if (start_ld) begin
      half_act <= half_nx;
      dt_act   <= dt_in;
    end
  end

  for (genvar p = 0; p < NPH; p++) begin : g_duty
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 duty_act[p*CNT_W +: CNT_W] <= '0;
      else if (start_ld || mid_ld) duty_act[p*CNT_W +: CNT_W] <= duty_in[p*CNT_W +: CNT_W];
    end
  end

  // single update: duties only move at a period start
  assert_single_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == UPD_SINGLE && !start_ld) |=> $stable(duty_act));

  // period and dead time never move at the midpoint
  assert_mid_keeps_period_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !start_ld |=> ($stable(half_act) && $stable(dt_act)));
endmodule

// File: rtl/pwm3_phase.sv
`timescale 1ns/1ps
module pwm3_phase #(
  parameter int CNT_W = 16,
  parameter int DT_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] tri_cnt,
  input  logic [CNT_W-1:0] half,
  input  logic [CNT_W-1:0] duty,
  input  logic [DT_W-1:0]  dt,
  output logic             hi_on,
  output logic             lo_on
);
  logic [CNT_W-1:0] k;
  logic [CNT_W-1:0] thr;
  logic             raw;
  logic             raw_q;
  logic [DT_W-1:0]  run;

  always_comb begin
    if (duty[CNT_W-1])   k = '0;
    else if (duty > half) k = half;
    else                  k = duty;
  end

  assign thr = half - k;
  assign raw = (tri_cnt >= thr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= 1'b0;
      run   <= '0;
    end else if (raw != raw_q) begin
      raw_q <= raw;
      run   <= '0;
    end else if (run != {DT_W{1'b1}}) begin
      run <= run + DT_W'(1);
    end
  end

  assign hi_on = raw_q && (run >= dt);
  assign lo_on = !raw_q && (run >= dt);

  // with a dead time, the high side is still off when the low side drops
  assert_gap_after_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(lo_on) && dt != '0) |-> !hi_on);
endmodule

// File: rtl/pwm3_outstage.sv
`timescale 1ns/1ps
module pwm3_outstage #(
  parameter int NPH = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           trip_n,
  input  logic           trip_clr,
  input  logic           booting,
  input  logic           act_high,
  input  logic [NPH-1:0] hi_on,
  input  logic [NPH-1:0] lo_on,
  output logic [NPH-1:0] hi_out,
  output logic [NPH-1:0] lo_out,
  output logic           tripped
);
  logic shut;

  always_ff @(posedge clk or negedge rst_n or negedge trip_n) begin
    if (!rst_n)        tripped <= 1'b0;
    else if (!trip_n)  tripped <= 1'b1;
    else if (trip_clr) tripped <= 1'b0;
  end

  assign shut   = !trip_n || tripped || booting;
  assign hi_out = (hi_on & {NPH{!shut}}) ^ {NPH{!act_high}};
  assign lo_out = (lo_on & {NPH{!shut}}) ^ {NPH{!act_high}};

  assert_trip_forces_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !trip_n |-> (hi_out == {NPH{!act_high}} && lo_out == {NPH{!act_high}}));

  assert_trip_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tripped && !(trip_clr && trip_n)) |=> tripped);
endmodule

// File: rtl/pwm3_center_gen.sv
`timescale 1ns/1ps
module pwm3_center_gen
  import pwm3_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DT_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] duty_a,
  input  logic [CNT_W-1:0] duty_b,
  input  logic [CNT_W-1:0] duty_c,
  input  logic [DT_W-1:0]  dead,
  input  logic             dbl_upd,
  input  logic             act_high,
  input  logic             sync_en,
  input  logic             sync_in,
  input  logic             trip_n,
  input  logic             trip_clr,
  output logic [2:0]       hi_out,
  output logic [2:0]       lo_out,
  output logic             sync_out,
  output logic             tripped
);
  localparam int NPH = PHASES;

  upd_mode_e              mode;
  logic [CNT_W-1:0]       half_act;
  logic [NPH*CNT_W-1:0]   duty_bus;
  logic [NPH*CNT_W-1:0]   duty_act;
  logic [DT_W-1:0]        dt_act;
  logic [CNT_W-1:0]       tri_cnt;
  logic                   start_ld;
  logic                   mid_ld;
  logic                   booting;
  logic [NPH-1:0]         hi_on;
  logic [NPH-1:0]         lo_on;

  assign mode     = upd_mode_e'(dbl_upd);
  assign duty_bus = {duty_c, duty_b, duty_a};

  pwm3_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .half(half_act),
    .ext_restart(sync_en & sync_in), .mode(mode),
    .tri_cnt(tri_cnt), .start_ld(start_ld), .mid_ld(mid_ld),
    .sync_out(sync_out), .booting(booting)
  );

  pwm3_shadow #(.CNT_W(CNT_W), .DT_W(DT_W), .NPH(NPH)) u_shadow (
    .clk(clk), .rst_n(rst_n), .start_ld(start_ld), .mid_ld(mid_ld),
    .mode(mode), .per_in(period), .duty_in(duty_bus), .dt_in(dead),
    .half_act(half_act), .duty_act(duty_act), .dt_act(dt_act)
  );

  for (genvar p = 0; p < NPH; p++) begin : g_phase
    pwm3_phase #(.CNT_W(CNT_W), .DT_W(DT_W)) u_phase (
      .clk(clk), .rst_n(rst_n), .tri_cnt(tri_cnt), .half(half_act),
      .duty(duty_act[p*CNT_W +: CNT_W]), .dt(dt_act),
      .hi_on(hi_on[p]), .lo_on(lo_on[p])
    );
  end

  pwm3_outstage #(.NPH(NPH)) u_out (
    .clk(clk), .rst_n(rst_n), .trip_n(trip_n), .trip_clr(trip_clr),
    .booting(booting), .act_high(act_high), .hi_on(hi_on), .lo_on(lo_on),
    .hi_out(hi_out), .lo_out(lo_out), .tripped(tripped)
  );

  // at the pins, no phase ever has both gates at the on level
  assert_no_both_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((hi_out ~^ {NPH{act_high}}) & (lo_out ~^ {NPH{act_high}})) == '0);
endmodule

// File: tb/pwm3_center_gen_test.sv
`timescale 1ns/1ps
module pwm3_center_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] period = 16'd20;
  logic [15:0] duty_a = '0, duty_b = '0, duty_c = '0;
  logic [7:0]  dead = '0;
  logic        dbl_upd = 1'b0, act_high = 1'b1, sync_en = 1'b0, sync_in = 1'b0;
  logic        trip_n = 1'b1, trip_clr = 1'b0;
  logic [2:0]  hi_out, lo_out;
  logic        sync_out, tripped;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  pwm3_center_gen uut (
    .clk(clk), .rst_n(rst_n), .period(period), .duty_a(duty_a), .duty_b(duty_b),
    .duty_c(duty_c), .dead(dead), .dbl_upd(dbl_upd), .act_high(act_high),
    .sync_en(sync_en), .sync_in(sync_in), .trip_n(trip_n), .trip_clr(trip_clr),
    .hi_out(hi_out), .lo_out(lo_out), .sync_out(sync_out), .tripped(tripped)
  );

  typedef struct packed {
    logic [15:0] per;
    logic [15:0] da;
    logic [15:0] db;
    logic [15:0] dc;
    logic [7:0]  dt;
    logic        pol;
    logic [15:0] exp_hi_a;
    logic [15:0] exp_lo_a;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{16'd20, 16'd4,    16'd0,  16'd10,   8'd2, 1'b1, 16'd6,  16'd10},
    '{16'd20, 16'd5,    16'd30, 16'hFFFD, 8'd0, 1'b1, 16'd10, 16'd10},
    '{16'd20, 16'd0,    16'd10, 16'd3,    8'd1, 1'b1, 16'd0,  16'd20},
    '{16'd20, 16'd10,   16'd4,  16'd1,    8'd3, 1'b1, 16'd20, 16'd0},
    '{16'd20, 16'hFFFD, 16'd7,  16'd9,    8'd2, 1'b1, 16'd0,  16'd20},
    '{16'd40, 16'd7,    16'd19, 16'd2,    8'd3, 1'b0, 16'd11, 16'd23},
    '{16'd16, 16'd1,    16'd2,  16'd8,    8'd5, 1'b1, 16'd0,  16'd9},
    '{16'd21, 16'd3,    16'd5,  16'd12,   8'd1, 1'b1, 16'd5,  16'd13},
    '{16'd40, 16'd30,   16'd20, 16'd1,    8'd0, 1'b0, 16'd40, 16'd0}
  };

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // expected counts from R3/R4
  function automatic int kval(input int h, input logic [15:0] d);
    if (d[15]) return 0;
    if (int'(d) > h) return h;
    return int'(d);
  endfunction

  function automatic int exp_hi(input int h, input logic [15:0] d, input int dt);
    int k = kval(h, d);
    if (k == 0) return 0;
    if (k == h) return 2 * h;
    return (2 * k - dt > 0) ? 2 * k - dt : 0;
  endfunction

  function automatic int exp_lo(input int h, input logic [15:0] d, input int dt);
    int k = kval(h, d);
    if (k == 0) return 2 * h;
    if (k == h) return 0;
    return (2 * h - 2 * k - dt > 0) ? 2 * h - 2 * k - dt : 0;
  endfunction

  task automatic wait_sync();
    do @(negedge clk); while (!sync_out);
  endtask

  int hcnt [3];
  int lcnt [3];
  int both_cnt;
  int extra_sync;
  logic sync_after;

  // count on-level cycles over one full period, starting at the current sync cycle
  task automatic count_window(input int h, input logic pol);
    for (int p = 0; p < 3; p++) begin hcnt[p] = 0; lcnt[p] = 0; end
    both_cnt = 0;
    extra_sync = 0;
    for (int c = 0; c < 2 * h; c++) begin
      if (c > 0) begin
        @(negedge clk);
        if (sync_out) extra_sync++;
      end
      for (int p = 0; p < 3; p++) begin
        if (hi_out[p] == pol) hcnt[p]++;
        if (lo_out[p] == pol) lcnt[p]++;
        if (hi_out[p] == pol && lo_out[p] == pol) both_cnt++;
      end
    end
    @(negedge clk);
    sync_after = sync_out;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R2: actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    // R1: reset state, both polarities
    repeat (3) @(negedge clk);
    chk("R1", "hi_out in reset", int'(hi_out), 0);
    chk("R1", "lo_out in reset", int'(lo_out), 0);
    chk("R1", "sync_out in reset", int'(sync_out), 0);
    chk("R1", "tripped in reset", int'(tripped), 0);
    act_high = 1'b0;
    #1;
    chk("R1", "hi_out in reset active-low", int'(hi_out), 7);
    act_high = 1'b1;
    rst_n = 1'b1;
    #1;
    chk("R1", "lo_out first cycle", int'(lo_out), 0);

    // vector table: R2, R3, R4, R7
    for (int v = 0; v < NV; v++) begin
      int h;
      period = VECS[v].per; duty_a = VECS[v].da; duty_b = VECS[v].db;
      duty_c = VECS[v].dc;  dead = VECS[v].dt;   act_high = VECS[v].pol;
      h = (int'(VECS[v].per) / 2 > 0) ? int'(VECS[v].per) / 2 : 1;
      wait_sync();
      wait_sync();
      count_window(h, VECS[v].pol);
      chk("R3_R4", $sformatf("v%0d hi A", v), hcnt[0], int'(VECS[v].exp_hi_a));
      chk("R3_R4", $sformatf("v%0d lo A", v), lcnt[0], int'(VECS[v].exp_lo_a));
      chk("R3_R4_R7", $sformatf("v%0d hi B", v), hcnt[1], exp_hi(h, VECS[v].db, int'(VECS[v].dt)));
      chk("R3_R4_R7", $sformatf("v%0d lo B", v), lcnt[1], exp_lo(h, VECS[v].db, int'(VECS[v].dt)));
      chk("R3_R4", $sformatf("v%0d hi C", v), hcnt[2], exp_hi(h, VECS[v].dc, int'(VECS[v].dt)));
      chk("R3_R4", $sformatf("v%0d lo C", v), lcnt[2], exp_lo(h, VECS[v].dc, int'(VECS[v].dt)));
      chk("R4", $sformatf("v%0d both on", v), both_cnt, 0);
      chk("R2", $sformatf("v%0d extra sync", v), extra_sync, 0);
      chk("R2", $sformatf("v%0d sync at 2H", v), int'(sync_after), 1);
    end

    // R5 / R6: duty change inside a period
    period = 16'd20; dead = 8'd0; act_high = 1'b1;
    duty_a = 16'd2; duty_b = 16'd0; duty_c = 16'd0;
    dbl_upd = 1'b0;
    wait_sync(); wait_sync();
    duty_a = 16'd6;
    count_window(10, 1'b1);
    chk("R5", "single update keeps old duty", hcnt[0], 4);
    duty_a = 16'd2; dbl_upd = 1'b1;
    wait_sync(); wait_sync();
    duty_a = 16'd6;
    count_window(10, 1'b1);
    chk("R6", "double update midpoint load", hcnt[0], 8);
    chk("R6", "double update low side", lcnt[0], 12);
    dbl_upd = 1'b0;

    // R8: external sync
    period = 16'd40; sync_en = 1'b1;
    wait_sync(); wait_sync();
    repeat (5) @(negedge clk);
    sync_in = 1'b1;
    @(negedge clk);
    sync_in = 1'b0;
    chk("R8", "restart on external sync", int'(sync_out), 1);
    sync_en = 1'b0;
    wait_sync();
    repeat (5) @(negedge clk);
    sync_in = 1'b1;
    @(negedge clk);
    sync_in = 1'b0;
    chk("R8", "sync ignored when disabled", int'(sync_out), 0);

    // R9 / R10: trip
    period = 16'd20; duty_a = 16'd10; duty_b = 16'd10; duty_c = 16'd10;
    wait_sync(); wait_sync();
    @(negedge clk);
    chk("R3", "full on before trip", int'(hi_out), 7);
    trip_n = 1'b0;
    #1;
    chk("R9", "trip hi off", int'(hi_out), 0);
    chk("R9", "trip lo off", int'(lo_out), 0);
    chk("R9", "trip flag set", int'(tripped), 1);
    trip_clr = 1'b1;
    repeat (2) @(negedge clk);
    trip_clr = 1'b0;
    trip_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10", "flag held after clear during trip", int'(tripped), 1);
    chk("R10", "outputs held off", int'(hi_out), 0);
    trip_clr = 1'b1;
    @(negedge clk);
    trip_clr = 1'b0;
    chk("R10", "flag cleared", int'(tripped), 0);
    chk("R10", "outputs resume", int'(hi_out), 7);

    act_high = 1'b0;
    @(negedge clk);
    chk("R7", "active-low full on", int'(hi_out), 0);
    trip_n = 1'b0;
    #1;
    chk("R7_R9", "active-low trip hi", int'(hi_out), 7);
    chk("R7_R9", "active-low trip lo", int'(lo_out), 7);
    @(negedge clk);
    trip_n = 1'b1;
    trip_clr = 1'b1;
    @(negedge clk);
    trip_clr = 1'b0;
    chk("R10", "active-low resume", int'(hi_out), 0);
    chk("R10", "active-low flag cleared", int'(tripped), 0);

    done = 1;
    summary();
    $finish;
  end
endmodule